// File: doc/BRIEF.md
# Converter Readout Serial Master

This block runs one read of a 12-bit, 4- or 8-channel serial analog-to-digital converter. The host raises a one-cycle start request and supplies a channel number and a single-ended/differential select. The block then pulls chip select low, runs 24 serial clocks and shifts out a zero-padded command, then drops chip select. The padding places the 12 result bits in the last 12 received bit slots. The result arrives MSB first, is latched in a holding register and is announced with a one-cycle done pulse.

A static input chooses the idle clock level. In both settings the outgoing line changes on falling serial-clock edges and the return line is sampled on rising ones. A built-in divider derives the serial clock from the system clock. A second start request that arrives during a read is not acted on.

Top module: `adc_frame_master`

## Requirements
- R1: While reset is asserted, `cs_n_o` is 1, `sclk_o` is 0, `done_o` and `busy_o` are 0 and `result_o` is 0.
- R2: One read produces exactly 24 rising edges of `sclk_o` while `cs_n_o` is 0.
- R3: The 24 bits on `mosi_o`, taken at rising edges and numbered 1 to 24, are: bits 1 to 5 are 0, bit 6 is 1, bit 7 is `single_ended_i` (1 = single-ended), bits 8 to 10 are `ch_i[2]`, `ch_i[1]`, `ch_i[0]`, and bits 11 to 24 are 0.
- R4: While `cs_n_o` is 0, `mosi_o` changes only in the cycle where `sclk_o` falls or where `cs_n_o` falls.
- R5: When idle, `sclk_o` equals `mode3_i` (0 gives low idle / mode 0, 1 gives high idle / mode 3).
- R6: `result_o` is made of the values of `miso_i` taken at rising edges 13 to 24, with the first of these as bit 11. Values at rising edges 1 to 12 have no effect.
- R7: `cs_n_o` falls at least `DIV_N` system cycles before the first `sclk_o` edge. It rises only after the 24th rising edge.
- R8: `done_o` is high for exactly one cycle, 49·`DIV_N` cycles after the clock edge that accepts the start. It is high in the same cycle that `cs_n_o` returns to 1 and `result_o` takes the new value.
- R9: A start request during a busy read is ignored. The command and the result of the running read are unchanged, and so is its completion time.
- R10: `result_o` holds its value whenever `done_o` is not asserted, including during the next read.
- R11: During a read, consecutive rising edges of `sclk_o` are 2·`DIV_N` system cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle read request |
| single_ended_i | input | 1 | 1 = single-ended input, 0 = differential pair |
| ch_i | input | 3 | Channel number |
| mode3_i | input | 1 | Static clock-idle select: 0 idle low, 1 idle high |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Command line to the converter |
| miso_i | input | 1 | Data line from the converter |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 12 | Last conversion result |

## Verification
The done pulse and the new result are due exactly 49·`DIV_N` system cycles after the edge that accepts start. The bench counts clock edges from that edge and samples at the falling system clock, so it compares the latency and the result value at that same cycle. Between these points, `result_o` is compared every cycle against its previous value. Serial-side timing (setup, edge spacing, bit alignment) is measured by a behavioural converter model. The model responds to `sclk_o` edges as they occur, drives 1 on every bit slot that should be skipped, and derives its result value from the command it decoded.

// File: rtl/adc_frame_pkg.sv
`timescale 1ns/1ps
package adc_frame_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2
  } afm_state_e;
endpackage

// File: rtl/afm_rst_sync.sv
`timescale 1ns/1ps
module afm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/afm_tick_gen.sv
`timescale 1ns/1ps
module afm_tick_gen #(
  parameter int DIV_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_N - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick_o = en_i && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)       cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/afm_rx_capture.sv
`timescale 1ns/1ps
module afm_rx_capture #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en_i,
  input  logic             miso_i,
  output logic [RES_W-1:0] word_o
);
  logic [RES_W-1:0] shift_q, shift_d;

  always_comb begin
    shift_d = shift_q;
    if (sample_en_i) shift_d = {shift_q[RES_W-2:0], miso_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign word_o = shift_q;
endmodule

// File: rtl/adc_frame_master.sv
`timescale 1ns/1ps
module adc_frame_master #(
  parameter int DIV_N      = 4,
  parameter int RES_W      = 12,
  parameter int CH_W       = 3,
  parameter int LEAD_ZEROS = 5,
  parameter int FRAME_LEN  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             single_ended_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic             mode3_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  import adc_frame_pkg::*;

  localparam int IDX_W   = $clog2(FRAME_LEN);
  localparam int CMD_PAD = FRAME_LEN - LEAD_ZEROS - 2 - CH_W;
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_LEN - 1);

  logic                 rst_q_n;
  afm_state_e           state_q, state_d;
  logic                 half_q, half_d;
  logic [IDX_W-1:0]     bit_q, bit_d;
  logic [FRAME_LEN-1:0] cmd_q, cmd_d;
  logic                 sclk_q, sclk_d;
  logic                 cs_n_q, cs_n_d;
  logic                 done_q, done_d;
  logic [RES_W-1:0]     result_q, result_d;
  logic                 tick;
  logic                 sample_en;
  logic [RES_W-1:0]     rx_word;
  logic [FRAME_LEN-1:0] cmd_word;

  assign cmd_word = {{LEAD_ZEROS{1'b0}}, 1'b1, single_ended_i, ch_i, {CMD_PAD{1'b0}}};

  afm_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  afm_tick_gen #(.DIV_N(DIV_N)) u_tick_gen (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .en_i   (state_q != ST_IDLE),
    .tick_o (tick)
  );

  assign sample_en = (state_q == ST_SHIFT) && tick && !half_q;

  afm_rx_capture #(.RES_W(RES_W)) u_rx_capture (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .sample_en_i (sample_en),
    .miso_i      (miso_i),
    .word_o      (rx_word)
  );

  always_comb begin
    state_d  = state_q;
    half_d   = half_q;
    bit_d    = bit_q;
    cmd_d    = cmd_q;
    sclk_d   = sclk_q;
    cs_n_d   = cs_n_q;
    done_d   = 1'b0;
    result_d = result_q;
    unique case (state_q)
      ST_IDLE: begin
        sclk_d = mode3_i;
        cs_n_d = 1'b1;
        if (start_i) begin
          state_d = ST_SETUP;
          cs_n_d  = 1'b0;
          cmd_d   = cmd_word;
          bit_d   = '0;
          half_d  = 1'b0;
        end
      end
      ST_SETUP: begin
        if (tick) begin
          state_d = ST_SHIFT;
          half_d  = 1'b0;
          sclk_d  = 1'b0;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!half_q) begin
            half_d = 1'b1;
            sclk_d = 1'b1;
          end else if (bit_q == LAST_BIT) begin
            state_d  = ST_IDLE;
            cs_n_d   = 1'b1;
            sclk_d   = mode3_i;
            cmd_d    = '0;
            done_d   = 1'b1;
            result_d = rx_word;
          end else begin
            bit_d  = bit_q + 1'b1;
            half_d = 1'b0;
            sclk_d = 1'b0;
            cmd_d  = {cmd_q[FRAME_LEN-2:0], 1'b0};
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q  <= ST_IDLE;
      half_q   <= 1'b0;
      bit_q    <= '0;
      cmd_q    <= '0;
      sclk_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      state_q  <= state_d;
      half_q   <= half_d;
      bit_q    <= bit_d;
      cmd_q    <= cmd_d;
      sclk_q   <= sclk_d;
      cs_n_q   <= cs_n_d;
      done_q   <= done_d;
      result_q <= result_d;
    end
  end

  assign cs_n_o   = cs_n_q;
  assign sclk_o   = sclk_q;
  assign mosi_o   = cmd_q[FRAME_LEN-1];
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/adc_frame_master_chk.sv
`timescale 1ns/1ps
module adc_frame_master_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             mode3_i,
  input logic             cs_n_o,
  input logic             sclk_o,
  input logic             mosi_o,
  input logic             done_o,
  input logic [RES_W-1:0] result_o
);
  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && !start_i) |=> (sclk_o == $past(mode3_i)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $rose(cs_n_o));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  // R4
  mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && !$fell(sclk_o) && !$fell(cs_n_o)) |-> $stable(mosi_o));

  // R9
  cs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> $past(start_i));
endmodule

bind adc_frame_master adc_frame_master_chk #(.RES_W(RES_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .start_i  (start_i),
  .mode3_i  (mode3_i),
  .cs_n_o   (cs_n_o),
  .sclk_o   (sclk_o),
  .mosi_o   (mosi_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/adc_frame_master_tb.sv
`timescale 1ns/1ps
module adc_frame_master_tb;
  localparam int N   = 2;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        single_ended = 1'b0;
  logic [2:0]  ch = 3'd0;
  logic        mode3 = 1'b0;
  logic        cs_n, sclk, mosi, busy, done;
  logic        miso = 1'b1;
  logic [11:0] result;

  int checks = 0;
  int fails  = 0;
  int trial  = 0;

  always #(PER/2) clk = ~clk;

  adc_frame_master #(.DIV_N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .single_ended_i(single_ended),
    .ch_i(ch), .mode3_i(mode3), .cs_n_o(cs_n), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .busy_o(busy), .done_o(done), .result_o(result)
  );

  function automatic logic [11:0] expv(input logic s, input logic [2:0] c, input int t);
    expv = 12'(((s ? 2048 : 0) + int'(c) * 300 + t * 37 + 5) % 4096);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural converter
  int          scnt;
  int          rise_cnt;
  logic [23:0] rx_cmd;
  logic [11:0] slave_val;
  time         t_cs, t_last_rise;
  time         setup_t;
  bit          first_seen;
  int          per_bad;

  always @(negedge cs_n) begin
    scnt = 0; rise_cnt = 0; miso = 1'b1; rx_cmd = '0;
    t_cs = $time; first_seen = 1'b0; per_bad = 0;
  end

  always @(posedge sclk) if (!cs_n) begin
    if (!first_seen) begin first_seen = 1'b1; setup_t = $time - t_cs; end
    scnt++; rise_cnt++;
    if (rise_cnt > 1 && ($time - t_last_rise) != 2 * N * PER) per_bad++;
    t_last_rise = $time;
    rx_cmd = {rx_cmd[22:0], mosi};
    if (scnt == 10) slave_val = expv(rx_cmd[3], rx_cmd[2:0], trial);
  end

  always @(negedge sclk) if (!cs_n) begin
    int pos;
    if (!first_seen) begin first_seen = 1'b1; setup_t = $time - t_cs; end
    pos = scnt + 1;
    if (pos < 12)       miso = 1'b1;
    else if (pos == 12) miso = 1'b1;
    else if (pos <= 24) miso = slave_val[24 - pos];
  end

  // R4 monitor at falling system clock
  logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_cs_n = 1'b1;
  int   r4_bad = 0;
  always @(negedge clk) begin
    if (rst_n && !cs_n && mosi != prev_mosi && !(prev_sclk && !sclk) && !prev_cs_n) r4_bad++;
    prev_sclk = sclk; prev_mosi = mosi; prev_cs_n = cs_n;
  end

  task automatic run(input logic m3, input logic s, input logic [2:0] c, input bit inject);
    logic [11:0] prev_res, exp_res;
    logic [23:0] exp_cmd;
    int k;
    int hold_bad;
    bit got;
    trial++;
    @(negedge clk);
    mode3 = m3;
    repeat (3) @(negedge clk);
    chk(sclk == m3, "R5 idle level", sclk, m3);
    prev_res = result;
    single_ended = s; ch = c; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0; hold_bad = 0; got = 1'b0;
    for (int i = 0; i < 49 * N + 20; i++) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
      if (result != prev_res) hold_bad++;
      if (inject && k == 10 * N) begin start = 1'b1; ch = ~c; single_ended = ~s; end
      else start = 1'b0;
    end
    start = 1'b0;
    exp_res = expv(s, c, trial);
    exp_cmd = {5'b0, 1'b1, s, c, 14'b0};
    chk(got && k == 49 * N, inject ? "R9 latency with ignored start" : "R8 done latency", k, 49 * N);
    chk(result == exp_res, inject ? "R9 result after ignored start" : "R6 result", result, exp_res);
    chk(rx_cmd == exp_cmd, inject ? "R9 command after ignored start" : "R3 command bits", rx_cmd, exp_cmd);
    chk(cs_n == 1'b1 && !busy, "R8 cs_n high with done", cs_n, 1);
    chk(sclk == m3, "R5 idle level after read", sclk, m3);
    chk(hold_bad == 0, "R10 result hold during read", hold_bad, 0);
    chk(rise_cnt == 24, "R2 rising edge count", rise_cnt, 24);
    chk(setup_t >= N * PER, "R7 cs setup", int'(setup_t), N * PER);
    chk(t_last_rise < $time, "R7 cs rise after last edge", int'(t_last_rise), int'($time));
    chk(per_bad == 0, "R11 clock period", per_bad, 0);
    chk(r4_bad == 0, "R4 mosi change point", r4_bad, 0);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
    repeat (4) @(negedge clk);
    chk(result == exp_res, "R10 result hold when idle", result, exp_res);
  endtask

  initial begin
    #(PER * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
    chk(!done && !busy, "R1 reset done/busy", {done, busy}, 0);
    chk(result == 12'd0, "R1 reset result", result, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        for (int c = 0; c < 8; c++)
          run(m[0], s[0], c[2:0], (c == 5) || (c == 2 && s == 1));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule